// File: doc/BRIEF.md
# Beacon and TSF timing unit

This block is the time base of a wireless MAC. Two cascaded programmable dividers turn the system clock into a 1 µs tick and then into a slot tick. With the default setting the slot tick is 64 µs, which is 1/16 of a 1024 µs time unit (TU). The 1 µs tick advances a 64-bit timing-synchronization counter. The slot tick drives a beacon down-counter. When that counter expires it raises a one-cycle pulse and can open an ATIM window for a programmed number of slots.

Software configures the block through a simple write port of four word registers. Register 0 sets the timebase: bits [7:0] give the clocks per µs and bits [15:8] give the µs per slot. Register 1 holds the run controls: bit 0 runs the counter, bit 1 runs the beacon timer and bit 2 enables the ATIM window. Bits [7:3] of register 1 are accepted for compatibility and have no effect. Register 2 gives the beacon interval in bits [15:0] and the ATIM window length in bits [31:16], both in slots. Register 3 bits [15:0] give the beacon preload in slots.

The outputs are the counter as two 32-bit words, a beacon-expired pulse, an ATIM-open flag and a 3-bit event vector. In the event vector, bit 0 marks a beacon expiry, bit 2 marks the closing of the ATIM window, and bit 1 is always 0.

Top module: `beacon_tsf_timer`

## Requirements
- R1: After reset the counter reads 0, and `bcn_exp`, `atim_open` and `evt` are all 0.
- R2: The µs tick occurs once every N clocks, where N is register 0 bits [7:0]. The slot tick occurs once every M µs ticks, where M is register 0 bits [15:8]. A field value of 0 behaves as 1.
- R3: While register 1 bit 0 is set, the 64-bit counter `{tsf_hi,tsf_lo}` rises by exactly one per µs tick. While that bit is clear, the counter holds its value.
- R4: While register 1 bit 1 is clear, the beacon counter holds the preload value. While it is set, the counter counts down by one per slot tick. A slot tick that finds the counter at 1 or 0 is an expiry. On an expiry the counter reloads the interval (register 2 bits [15:0]) and `bcn_exp` is high for the single following cycle. The first expiry therefore comes after `preload` slots and later expiries come every `interval` slots.
- R5: When register 1 bits 0 and 1 are both clear, both dividers return to zero. The first µs tick after either bit is set falls on the N-th clock of running.
- R6: A write to register 3 while the beacon timer runs takes effect at the next slot tick. That tick loads the new preload value in place of counting or expiring, which restarts the beacon schedule.
- R7: With register 1 bit 2 set and a window W (register 2 bits [31:16]) greater than 0, `atim_open` rises in the cycle of `bcn_exp` and stays high for W slot ticks. When it falls, `evt` bit 2 pulses. An expiry while the window is open restarts the window. With bit 2 clear, or W equal to 0, `atim_open` stays 0.
- R8: `evt` bit 0 equals `bcn_exp` in every cycle, `evt` bit 2 marks the ATIM close, and `evt` bit 1 is always 0.
- R9: Register 1 bits [7:3] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 timebase, 1 control, 2 interval/window, 3 preload) |
| wr_data | input | 32 | Register write data |
| tsf_lo | output | 32 | Low word of the timing counter |
| tsf_hi | output | 32 | High word of the timing counter |
| bcn_exp | output | 1 | One-cycle beacon expiry pulse |
| atim_open | output | 1 | High while the ATIM window is open |
| evt | output | 3 | Event pulses: bit 0 beacon expiry, bit 1 zero, bit 2 ATIM close |

## Verification
The assertions assume that software writes one register per cycle and that reset is held for at least one clock edge. They also assume the counter never wraps, so that the step-by-one property on the counter is valid. The stimulus changes the timebase only while both run bits are clear, and it never reaches counter values near 2^64, so all of these assumptions hold. Beacon and ATIM events are predicted from the register values and the cycle of the enabling write. The bench then matches them against the outputs in order. One scenario writes a new preload while the beacon timer is running, and another uses a window longer than the interval.

// File: rtl/bt_pkg.sv
package bt_pkg;
    localparam int REG_AW = 2;
    localparam int REG_DW = 32;
    localparam int PRE_W  = 8;
    localparam int SPAN_W = 16;
    localparam int TSF_W  = 64;
    localparam int EV_W   = 3;
    localparam int NSTAGE = 2;

    localparam int CTL_TSF  = 0;
    localparam int CTL_BCN  = 1;
    localparam int CTL_ATIM = 2;

    typedef enum logic [REG_AW-1:0] {
        RA_TIMEBASE = 2'd0,
        RA_CONTROL  = 2'd1,
        RA_SPAN     = 2'd2,
        RA_PRELOAD  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [PRE_W-1:0]  clk_per_us;
        logic [PRE_W-1:0]  us_per_slot;
        logic              tsf_run;
        logic              bcn_run;
        logic              atim_en;
        logic [SPAN_W-1:0] interval;
        logic [SPAN_W-1:0] window;
        logic [SPAN_W-1:0] preload;
    } cfg_t;

    function automatic logic [PRE_W-1:0] last_count(input logic [PRE_W-1:0] period);
        return (period == '0) ? '0 : period - 1'b1;
    endfunction
endpackage

// File: rtl/bt_cfg_regs.sv
module bt_cfg_regs import bt_pkg::*; #(
    parameter int DEF_CLK_PER_US  = 100,
    parameter int DEF_US_PER_SLOT = 64,
    parameter int DEF_INTERVAL    = 1600
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [REG_DW-1:0] wr_data,
    output cfg_t              cfg,
    output logic              preload_wr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.clk_per_us  <= PRE_W'(DEF_CLK_PER_US);
            cfg.us_per_slot <= PRE_W'(DEF_US_PER_SLOT);
            cfg.tsf_run     <= 1'b0;
            cfg.bcn_run     <= 1'b0;
            cfg.atim_en     <= 1'b0;
            cfg.interval    <= SPAN_W'(DEF_INTERVAL);
            cfg.window      <= '0;
            cfg.preload     <= '0;
            preload_wr      <= 1'b0;
        end else begin
            preload_wr <= 1'b0;
            if (wr_en) begin
                case (reg_addr_e'(wr_addr))
                    RA_TIMEBASE: begin
                        cfg.clk_per_us  <= wr_data[PRE_W-1:0];
                        cfg.us_per_slot <= wr_data[2*PRE_W-1:PRE_W];
                    end
                    RA_CONTROL: begin
                        cfg.tsf_run <= wr_data[CTL_TSF];
                        cfg.bcn_run <= wr_data[CTL_BCN];
                        cfg.atim_en <= wr_data[CTL_ATIM];
                    end
                    RA_SPAN: begin
                        cfg.interval <= wr_data[SPAN_W-1:0];
                        cfg.window   <= wr_data[2*SPAN_W-1:SPAN_W];
                    end
                    RA_PRELOAD: begin
                        cfg.preload <= wr_data[SPAN_W-1:0];
                        preload_wr  <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/bt_tick_div.sv
module bt_tick_div import bt_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             in_tick,
    input  logic [PRE_W-1:0] period,
    output logic             out_tick
);
    logic [PRE_W-1:0] cnt;

    assign out_tick = run && in_tick && (cnt == last_count(period));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (in_tick) begin
            cnt <= out_tick ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bt_beacon_ctr.sv
module bt_beacon_ctr import bt_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              atim_en,
    input  logic              slot_tick,
    input  logic              preload_wr,
    input  logic [SPAN_W-1:0] preload,
    input  logic [SPAN_W-1:0] interval,
    input  logic [SPAN_W-1:0] window,
    output logic              bcn_exp,
    output logic              atim_open,
    output logic              atim_done
);
    localparam logic [SPAN_W-1:0] ONE = SPAN_W'(1);

    logic [SPAN_W-1:0] bcnt;
    logic [SPAN_W-1:0] acnt;
    logic              pend;
    logic              load;
    logic              hit;

    assign load      = pend || preload_wr;
    assign hit       = run && slot_tick && !load && (bcnt <= ONE);
    assign atim_open = (acnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            bcnt    <= '0;
            pend    <= 1'b0;
            bcn_exp <= 1'b0;
        end else begin
            bcn_exp <= hit;
            if (!run) begin
                bcnt <= preload;
                pend <= 1'b0;
            end else if (slot_tick) begin
                pend <= 1'b0;
                if (load)     bcnt <= preload;
                else if (hit) bcnt <= interval;
                else          bcnt <= bcnt - 1'b1;
            end else if (preload_wr) begin
                pend <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !atim_en) begin
            acnt      <= '0;
            atim_done <= 1'b0;
        end else begin
            atim_done <= slot_tick && !hit && (acnt == ONE);
            if (hit)                          acnt <= window;
            else if (slot_tick && acnt != '0) acnt <= acnt - 1'b1;
        end
    end
endmodule

// File: rtl/beacon_tsf_timer.sv
module beacon_tsf_timer import bt_pkg::*; #(
    parameter int DEF_CLK_PER_US  = 100,
    parameter int DEF_US_PER_SLOT = 64,
    parameter int DEF_INTERVAL    = 1600
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [REG_DW-1:0] wr_data,
    output logic [TSF_W/2-1:0] tsf_lo,
    output logic [TSF_W/2-1:0] tsf_hi,
    output logic              bcn_exp,
    output logic              atim_open,
    output logic [EV_W-1:0]   evt
);
    cfg_t               cfg_q;
    logic               preload_wr;
    logic               pre_run;
    logic [NSTAGE:0]    chain;
    logic [NSTAGE-1:0][PRE_W-1:0] periods;
    logic [TSF_W-1:0]   tsf;
    logic               atim_done;

    bt_cfg_regs #(
        .DEF_CLK_PER_US (DEF_CLK_PER_US),
        .DEF_US_PER_SLOT(DEF_US_PER_SLOT),
        .DEF_INTERVAL   (DEF_INTERVAL)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cfg       (cfg_q),
        .preload_wr(preload_wr)
    );

    assign pre_run  = cfg_q.tsf_run || cfg_q.bcn_run;
    assign periods  = {cfg_q.us_per_slot, cfg_q.clk_per_us};
    assign chain[0] = 1'b1;

    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        bt_tick_div u_div (
            .clk     (clk),
            .rst     (rst),
            .run     (pre_run),
            .in_tick (chain[s]),
            .period  (periods[s]),
            .out_tick(chain[s+1])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)                          tsf <= '0;
        else if (cfg_q.tsf_run && chain[1]) tsf <= tsf + 1'b1;
    end

    bt_beacon_ctr u_bcn (
        .clk       (clk),
        .rst       (rst),
        .run       (cfg_q.bcn_run),
        .atim_en   (cfg_q.atim_en),
        .slot_tick (chain[NSTAGE]),
        .preload_wr(preload_wr),
        .preload   (cfg_q.preload),
        .interval  (cfg_q.interval),
        .window    (cfg_q.window),
        .bcn_exp   (bcn_exp),
        .atim_open (atim_open),
        .atim_done (atim_done)
    );

    assign tsf_lo = tsf[TSF_W/2-1:0];
    assign tsf_hi = tsf[TSF_W-1:TSF_W/2];
    assign evt    = {atim_done, 1'b0, bcn_exp};
endmodule

// File: rtl/bt_checker.sv
module bt_checker (
    input logic        clk,
    input logic        rst,
    input logic        tsf_run,
    input logic        bcn_run,
    input logic [31:0] tsf_lo,
    input logic [31:0] tsf_hi,
    input logic        bcn_exp,
    input logic        atim_open,
    input logic [2:0]  evt
);
    logic [63:0] tsf_now;
    assign tsf_now = {tsf_hi, tsf_lo};

    // R3: counter frozen while its run bit is clear
    a_r3_tsf_hold: assert property (@(posedge clk) disable iff (rst)
        !tsf_run |=> $stable(tsf_now));

    // R3: counter never moves by more than one per cycle
    a_r3_tsf_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (tsf_now == $past(tsf_now)) || (tsf_now == $past(tsf_now) + 64'd1));

    // R4: an expiry needs the beacon timer running
    a_r4_exp_needs_run: assert property (@(posedge clk) disable iff (rst)
        bcn_exp |-> $past(bcn_run));

    // R7: window only opens on a beacon expiry
    a_r7_open_on_beacon: assert property (@(posedge clk) disable iff (rst)
        $rose(atim_open) |-> bcn_exp);

    // R7: the close event coincides with the window falling
    a_r7_close_event: assert property (@(posedge clk) disable iff (rst)
        evt[2] |-> (!atim_open && $past(atim_open)));
endmodule

bind beacon_tsf_timer bt_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .tsf_run  (cfg_q.tsf_run),
    .bcn_run  (cfg_q.bcn_run),
    .tsf_lo   (tsf_lo),
    .tsf_hi   (tsf_hi),
    .bcn_exp  (bcn_exp),
    .atim_open(atim_open),
    .evt      (evt)
);

// File: tb/beacon_tsf_timer_tb.sv
`timescale 1ns/1ps
module beacon_tsf_timer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] tsf_lo, tsf_hi;
    logic        bcn_exp, atim_open;
    logic [2:0]  evt;

    beacon_tsf_timer u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tsf_lo(tsf_lo), .tsf_hi(tsf_hi), .bcn_exp(bcn_exp),
        .atim_open(atim_open), .evt(evt)
    );

    always #5 clk = ~clk;

    typedef struct {
        int    kind;
        int    k;
        string req;
    } ev_t;

    ev_t  sb[$];
    int   cyc = 0;
    int   base = 0;
    int   n_chk = 0;
    int   n_err = 0;
    bit   mon_on = 1'b0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d (k=%0d)", req, act, exp, cyc - base);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input bit setbase);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        if (setbase) base = cyc;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_k(input int k);
        while (cyc - base != k) @(negedge clk);
    endtask

    task automatic expect_ev(input int kind, input int k, input string req);
        ev_t e;
        e.kind = kind; e.k = k; e.req = req;
        sb.push_back(e);
    endtask

    task automatic pop_cmp(input int kind);
        ev_t e;
        if (sb.size() == 0) begin
            check(1'b0, "R4 R7 unexpected event", kind, -1);
        end else begin
            e = sb.pop_front();
            check(e.kind == kind, {e.req, " event kind"}, kind, e.kind);
            check(e.k == cyc - base, {e.req, " event cycle"}, cyc - base, e.k);
        end
    endtask

    // monitor: R8 event vector consistency and scoreboard matching
    always @(negedge clk) begin
        if (mon_on && !done) begin
            if (bcn_exp !== evt[0]) check(1'b0, "R8 evt0 vs bcn_exp", evt[0], bcn_exp);
            if (evt[1] !== 1'b0)    check(1'b0, "R8 evt1 zero", evt[1], 0);
            if (evt[0]) pop_cmp(0);
            if (evt[2]) pop_cmp(2);
        end
    end

    function automatic longint tsf_val();
        return {tsf_hi, tsf_lo};
    endfunction

    task automatic sb_empty(input string req);
        check(sb.size() == 0, req, sb.size(), 0);
        sb.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        longint t0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(tsf_val() == 0, "R1 tsf", tsf_val(), 0);
        check(bcn_exp == 0, "R1 bcn_exp", bcn_exp, 0);
        check(atim_open == 0, "R1 atim_open", atim_open, 0);
        check(evt == 0, "R1 evt", evt, 0);

        // Scenario B: 4 clk/us, 2 us/slot, interval 3, window 1, preload 2, ignored bits set (R9)
        wr(2'd0, {16'd0, 8'd2, 8'd4}, 1'b0);
        wr(2'd2, {16'd1, 16'd3}, 1'b0);
        wr(2'd3, 32'd2, 1'b0);
        expect_ev(0, 16, "R4 R9"); expect_ev(2, 24, "R7 R9");
        expect_ev(0, 40, "R4");    expect_ev(2, 48, "R7");
        expect_ev(0, 64, "R4");    expect_ev(2, 72, "R7");
        expect_ev(0, 88, "R4");    expect_ev(2, 96, "R7");
        mon_on = 1'b1;
        wr(2'd1, 32'h0000_00FF, 1'b1);
        check(tsf_val() == 0, "R5 tsf at start", tsf_val(), 0);
        wait_k(4);   check(tsf_val() == 1, "R2 first us tick", tsf_val(), 1);
        wait_k(16);  check(bcn_exp == 1, "R4 first expiry", bcn_exp, 1);
                     check(atim_open == 1, "R7 window opens", atim_open, 1);
        wait_k(17);  check(bcn_exp == 0, "R4 single pulse", bcn_exp, 0);
        wait_k(20);  check(atim_open == 1, "R7 window held", atim_open, 1);
        wait_k(24);  check(atim_open == 0, "R7 window closes", atim_open, 0);
        wait_k(100); check(tsf_val() == 25, "R2 R3 tsf count", tsf_val(), 25);
                     check(tsf_hi == 0, "R3 tsf high word", tsf_hi, 0);
        wait_k(101); sb_empty("R4 R7 schedule B complete");
        wr(2'd1, 32'd0, 1'b1);
        check(tsf_val() == 25, "R3 hold after stop", tsf_val(), 25);
        wait_k(30);  check(tsf_val() == 25, "R3 R5 hold while stopped", tsf_val(), 25);

        // Scenario C: window 5 longer than interval 3 -> restart, never closes
        wr(2'd2, {16'd5, 16'd3}, 1'b0);
        for (int i = 0; i < 8; i++) expect_ev(0, 16 + 24 * i, "R4 R7 restart");
        wr(2'd1, 32'd7, 1'b1);
        wait_k(16);  check(atim_open == 1, "R7 open C", atim_open, 1);
        wait_k(30);  check(atim_open == 1, "R7 open k30", atim_open, 1);
        wait_k(100); check(atim_open == 1, "R7 open k100", atim_open, 1);
        wait_k(200); check(atim_open == 1, "R7 open k200", atim_open, 1);
                     check(tsf_val() == 75, "R3 tsf C", tsf_val(), 75);
        wait_k(201); sb_empty("R7 no close events C");
        wr(2'd1, 32'd0, 1'b1);
        wait_k(1);   check(atim_open == 0, "R7 enable clear", atim_open, 0);

        // Scenario D: beacon only, ATIM disabled, preload rewrite mid-run
        wr(2'd2, {16'd3, 16'd3}, 1'b0);
        expect_ev(0, 16, "R4 D"); expect_ev(0, 40, "R4 D"); expect_ev(0, 88, "R6 restart");
        wr(2'd1, 32'd2, 1'b1);
        t0 = tsf_val();
        wait_k(17);  check(atim_open == 0, "R7 atim disabled", atim_open, 0);
        wait_k(41);
        wr(2'd3, 32'd5, 1'b0);
        wait_k(64);  check(bcn_exp == 0, "R6 old schedule dropped", bcn_exp, 0);
        wait_k(88);  check(bcn_exp == 1, "R6 new schedule", bcn_exp, 1);
                     check(tsf_val() == t0, "R3 tsf off in D", tsf_val(), t0);
        wait_k(90);  sb_empty("R6 schedule D complete");
        wr(2'd1, 32'd0, 1'b1);

        // Scenario F: zero timebase fields behave as 1
        wr(2'd0, 32'd0, 1'b0);
        wr(2'd1, 32'd1, 1'b1);
        t0 = tsf_val();
        wait_k(10);  check(tsf_val() == t0 + 10, "R2 zero divider", tsf_val(), t0 + 10);
        wait_k(12);  sb_empty("R4 no beacon F");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule